// File: doc/BRIEF.md
# Receiver input sample port

This block is the front of a digital downconverter. It registers every incoming converter word on the rising clock edge: a 16-bit sample, a 3-bit exponent, a channel-select line, a word-valid qualifier and a soft-reset request. It then hands the data to the mixer stage that follows, together with per-channel valid flags and an internal data strobe.

The port has two operating modes. In dual-channel real mode the select line steers each valid word either to channel A (select high) or to channel B (select low). In single-channel complex mode a word with select high is an in-phase sample and is held. The next word with select low is its quadrature partner, and the pair is emitted together. Mode changes are made only around a soft reset.

After a soft reset, and after a hard reset, the port holds its output off. The hold lasts until a fixed number of valid words have passed, and this count is taken in qualified samples, not in clocks. With one word per clock the hold lasts seven clocks. With one word every fourth clock it lasts 28 clocks.

Top module: `rx_sample_port`

## Requirements
- R1: A valid word captured on one rising edge appears on the outputs after the next rising edge, so it is visible two edges after it is driven.
- R2: While a soft reset word is being processed, and until the hold-off count completes, `a_valid`, `b_valid` and `data_stb` stay low.
- R3: After a soft or hard reset, the first HOLD_SAMPLES (default 7) valid words are discarded, and the word after them is the first one forwarded. The soft-reset word itself does not count.
- R4: Only words with `in_valid` high advance the hold-off. When valid words arrive every fourth clock, the hold covers 28 clocks.
- R5: In dual-channel real mode (`cplx_mode` = 0), a valid word with `ab_sel` = 1 loads `a_data`/`a_exp` and pulses `a_valid` alone. A valid word with `ab_sel` = 0 loads `b_data`/`b_exp` and pulses `b_valid` alone.
- R6: In complex mode (`cplx_mode` = 1), a word with `ab_sel` = 1 is held as I. The next word with `ab_sel` = 0 puts I on `a_*` and itself on `b_*`, and `a_valid` and `b_valid` pulse together. A second I before a Q replaces the held I.
- R7: In complex mode, a Q word with no I held produces no output. An I word held before a soft reset is dropped.
- R8: A word with `in_valid` low produces no strobe and leaves all data outputs unchanged.
- R9: Hard reset (`rst_n` low, asynchronous) clears all outputs to zero.
- R10: `data_stb` is high exactly in the cycles in which `a_valid` or `b_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset request, registered with the word |
| cplx_mode | input | 1 | 1 = single-channel complex, 0 = dual-channel real |
| in_valid | input | 1 | Word qualifier, active high |
| ab_sel | input | 1 | Channel / I-Q select |
| in_data | input | 16 | Two's complement sample |
| in_exp | input | 3 | Sample exponent, passed through |
| a_data | output | 16 | Channel A or I sample |
| a_exp | output | 3 | Exponent for a_data |
| a_valid | output | 1 | One-cycle pulse for new a_data |
| b_data | output | 16 | Channel B or Q sample |
| b_exp | output | 3 | Exponent for b_data |
| b_valid | output | 1 | One-cycle pulse for new b_data |
| data_stb | output | 1 | Internal data strobe to the mixer |

## Verification
Every result is due two rising edges after its word is driven. The first edge is the capture register and the second is the output register. The bench drives on falling edges and keeps a two-deep queue of expected output states, so each falling edge compares the outputs with the state predicted from the word driven two steps earlier. The hold-off is also timed directly. After a soft reset with quarter-rate input, the first strobe must be seen exactly 31 steps after the reset word: 28 clocks of hold, one forwarded word, then the two-edge latency.

// File: rtl/rx_sample_port.sv
module rx_sample_port #(
  parameter int DATA_W = 16,
  parameter int EXP_W = 3,
  parameter int HOLD_SAMPLES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cplx_mode,
  input  logic              in_valid,
  input  logic              ab_sel,
  input  logic [DATA_W-1:0] in_data,
  input  logic [EXP_W-1:0]  in_exp,
  output logic [DATA_W-1:0] a_data,
  output logic [EXP_W-1:0]  a_exp,
  output logic              a_valid,
  output logic [DATA_W-1:0] b_data,
  output logic [EXP_W-1:0]  b_exp,
  output logic              b_valid,
  output logic              data_stb
);
  localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);
  localparam logic [CNT_W-1:0] HOLD = CNT_W'(HOLD_SAMPLES);

  logic [DATA_W-1:0] cap_d, i_d;
  logic [EXP_W-1:0]  cap_e, i_e;
  logic              cap_ab, cap_v, cap_srst;
  logic [CNT_W-1:0]  hold_cnt;
  logic              pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d    <= '0;
      cap_e    <= '0;
      cap_ab   <= 1'b0;
      cap_v    <= 1'b0;
      cap_srst <= 1'b0;
    end else begin
      cap_d    <= in_data;
      cap_e    <= in_exp;
      cap_ab   <= ab_sel;
      cap_v    <= in_valid;
      cap_srst <= soft_rst;
    end
  end

  wire ready  = (hold_cnt == HOLD);
  wire take   = cap_v & ~cap_srst;
  wire pair   = ~cap_ab & pend;
  wire emit_a = take & ready & (cplx_mode ? pair : cap_ab);
  wire emit_b = take & ready & (cplx_mode ? pair : ~cap_ab);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      pend     <= 1'b0;
      i_d      <= '0;
      i_e      <= '0;
      a_data   <= '0;
      a_exp    <= '0;
      b_data   <= '0;
      b_exp    <= '0;
      a_valid  <= 1'b0;
      b_valid  <= 1'b0;
      data_stb <= 1'b0;
    end else if (cap_srst) begin
      hold_cnt <= '0;
      pend     <= 1'b0;
      a_valid  <= 1'b0;
      b_valid  <= 1'b0;
      data_stb <= 1'b0;
    end else begin
      if (take && !ready) hold_cnt <= hold_cnt + 1'b1;
      a_valid  <= emit_a;
      b_valid  <= emit_b;
      data_stb <= emit_a | emit_b;
      if (emit_a) begin
        a_data <= cplx_mode ? i_d : cap_d;
        a_exp  <= cplx_mode ? i_e : cap_e;
      end
      if (emit_b) begin
        b_data <= cap_d;
        b_exp  <= cap_e;
      end
      if (!cplx_mode) pend <= 1'b0;
      else if (take && ready) begin
        if (cap_ab) begin
          pend <= 1'b1;
          i_d  <= cap_d;
          i_e  <= cap_e;
        end else pend <= 1'b0;
      end
    end
  end

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != HOLD) |=> !data_stb);
  // R2
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_srst |=> !(a_valid || b_valid || data_stb));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= HOLD);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_v |=> (!a_valid && !b_valid && $stable(a_data) && $stable(b_data)));
  // R5
  dual_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cplx_mode |=> (cplx_mode || $onehot0({a_valid, b_valid})));
  // R6
  cplx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cplx_mode |=> (!cplx_mode || (a_valid == b_valid)));
  // R1
  a_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ready && !cplx_mode && cap_ab) |=> (a_valid && a_data == $past(cap_d)));
  // R10
  stb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_stb) |-> (a_valid || b_valid));
endmodule

// File: tb/tb_rx_sample_port.sv
module tb_rx_sample_port;
  localparam int HOLD = 7;

  typedef struct packed {
    logic        av, bv, stb;
    logic [15:0] ad, bd;
    logic [2:0]  ae, be;
  } obs_t;

  logic clk = 0, rst_n = 0, soft_rst = 0, cplx_mode = 0, in_valid = 0, ab_sel = 0;
  logic [15:0] in_data = 0;
  logic [2:0]  in_exp = 0;
  logic [15:0] a_data, b_data;
  logic [2:0]  a_exp, b_exp;
  logic        a_valid, b_valid, data_stb;

  int checks = 0, errors = 0, step_no = 0;
  int arm_step = -1, first_seen = -1;
  obs_t p1, p2, mst;
  string t1, t2;
  int m_cnt = 0;
  bit m_pend = 0;
  logic [15:0] m_id = 0;
  logic [2:0]  m_ie = 0;
  logic next_mode = 0;

  always #2.5 clk = ~clk;

  rx_sample_port dut (.clk, .rst_n, .soft_rst, .cplx_mode, .in_valid, .ab_sel,
    .in_data, .in_exp, .a_data, .a_exp, .a_valid, .b_data, .b_exp, .b_valid, .data_stb);

  function automatic obs_t now_obs();
    obs_t o;
    o.av = a_valid; o.bv = b_valid; o.stb = data_stb;
    o.ad = a_data; o.bd = b_data; o.ae = a_exp; o.be = b_exp;
    return o;
  endfunction

  task automatic check(input obs_t exp_o, input string tag);
    obs_t got = now_obs();
    checks++;
    if (got !== exp_o) begin
      errors++;
      $display("FAIL %s step %0d: got %h expected %h", tag, step_no, got, exp_o);
    end
  endtask

  task automatic step(input bit srst, input bit v, input bit ab,
                      input logic [15:0] d, input logic [2:0] e, input string tag);
    @(negedge clk);
    step_no++;
    check(p2, t2);
    if (arm_step >= 0 && first_seen < 0 && data_stb) first_seen = step_no;
    p2 = p1; t2 = t1;
    mst.av = 0; mst.bv = 0;
    if (srst) begin
      m_cnt = 0; m_pend = 0;
    end else if (v) begin
      if (m_cnt < HOLD) m_cnt++;
      else if (!next_mode) begin
        if (ab) begin mst.av = 1; mst.ad = d; mst.ae = e; end
        else    begin mst.bv = 1; mst.bd = d; mst.be = e; end
      end else if (ab) begin
        m_pend = 1; m_id = d; m_ie = e;
      end else if (m_pend) begin
        mst.av = 1; mst.ad = m_id; mst.ae = m_ie;
        mst.bv = 1; mst.bd = d; mst.be = e;
        m_pend = 0;
      end
    end
    mst.stb = mst.av | mst.bv;
    p1 = mst; t1 = tag;
    cplx_mode = next_mode;
    soft_rst = srst; in_valid = v; ab_sel = ab; in_data = d; in_exp = e;
  endtask

  task automatic restart(input bit mode, input string tag);
    step(0, 0, 0, 16'h0, 3'h0, tag);
    next_mode = mode;
    step(1, 1, 1, 16'hdead, 3'h7, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mst = '0; p1 = '0; p2 = '0; t1 = "R9"; t2 = "R9";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check('0, "R9 hard reset state");
    rst_n = 1;

    // R3: seven words after hard reset are dropped, the eighth goes through (R1, R5)
    for (int i = 0; i < 12; i++)
      step(0, 1, i[0], 16'(16'h1000 + i), 3'(i), "R3 hold after hard reset");

    // R5 / R1 / R10: dual mode sweep of select and data
    for (int i = 0; i < 256; i++)
      step(0, 1, i[2] ^ i[0], 16'(i * 16'h0101 ^ 16'h8000), 3'(i >> 1), "R5 dual steering");

    // R8: invalid words leave outputs untouched
    for (int i = 0; i < 64; i++)
      step(0, i[1] & i[0], i[2], 16'(i * 977), 3'(i), "R8 invalid ignored");

    // R2 / R3: soft reset at full rate, seven-clock hold
    restart(0, "R2 soft reset quiet");
    for (int i = 0; i < 10; i++)
      step(0, 1, 1, 16'(16'h2000 + i), 3'(i), "R3 full rate hold");

    // R4: quarter-rate hold lasts 28 clocks
    restart(0, "R2 soft reset quiet");
    arm_step = step_no;
    for (int i = 0; i < 28; i++)
      step(0, (i % 4) == 0, 0, 16'(16'h3000 + i), 3'(i), "R4 quarter rate hold");
    step(0, 1, 1, 16'h3abc, 3'h5, "R4 first word after hold");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 16'h0, 3'h0, "R4 flush");
    checks++;
    if (first_seen != arm_step + 31) begin
      errors++;
      $display("FAIL R4 first strobe step got %0d expected %0d", first_seen, arm_step + 31);
    end

    // R6 / R7: complex mode
    restart(1, "R2 soft reset quiet");
    for (int i = 0; i < 7; i++) step(0, 1, i[0], 16'h4000, 3'h1, "R3 complex hold");
    step(0, 1, 0, 16'h4111, 3'h2, "R7 orphan Q dropped");
    step(0, 1, 1, 16'h4222, 3'h3, "R6 I held");
    step(0, 1, 1, 16'h4333, 3'h4, "R6 I replaced");
    step(0, 0, 0, 16'h4444, 3'h5, "R8 gap in pair");
    step(0, 1, 0, 16'h4555, 3'h6, "R6 pair emitted");
    step(0, 1, 0, 16'h4666, 3'h7, "R7 second Q dropped");
    for (int i = 0; i < 200; i++)
      step(0, (i % 3) != 2, i[0] ^ i[3], 16'(i * 16'h0357), 3'(i + 2), "R6 complex sweep");
    step(0, 1, 1, 16'h5111, 3'h1, "R7 I before reset");
    restart(1, "R7 pending I cleared");
    for (int i = 0; i < 7; i++) step(0, 1, 1, 16'h5200, 3'h0, "R3 complex hold");
    step(0, 1, 0, 16'h5333, 3'h3, "R7 Q after reset dropped");
    step(0, 1, 1, 16'h5444, 3'h4, "R6 I");
    step(0, 1, 0, 16'h5555, 3'h5, "R6 Q");

    // back to dual mode with random traffic
    restart(0, "R2 soft reset quiet");
    for (int i = 0; i < 300; i++)
      step(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           16'($urandom), 3'($urandom), "R5 random dual");
    step(0, 0, 0, 16'h0, 3'h0, "R8 flush");
    step(0, 0, 0, 16'h0, 3'h0, "R8 flush");
    step(0, 0, 0, 16'h0, 3'h0, "R8 flush");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule